// File: doc/BRIEF.md
# Bus initiator error status monitor

This block observes the transactions started by a PCI-style bus initiator and keeps a record of three error outcomes in a 32-bit status word. The outcomes are:

- a retry error, when the addressed target has pushed one transaction back with retry disconnects too many times;
- an initiator abort, when no target claims a cycle before the subtractive-decode deadline runs out;
- a target abort, when the addressed target ends the cycle with an abort.

The retry limit is an 8-bit input, and a value of zero lets a transaction be retried without end.

Software reads the status word and clears individual flags by writing 1 to their positions. A per-flag enable mask decides which flags reach a single registered interrupt line. The block only watches the bus and never drives it. It carries no data path, so every pin is a plain control or status signal.

Bus-side inputs are single-cycle event pulses sampled on the rising clock edge, except `tgt_devsel`, which is a level. The initiator marks each address phase with `addr_start`. When that address phase re-issues a transaction the target retried, it also raises `addr_is_retry`.

Top module: `init_err_monitor`

## Requirements
- R1: `sts_rd_data` is 32 bits with msb-0 numbering. Bit 5 (lsb index 26) is the retry error flag, bit 6 (lsb index 25) is the initiator abort flag and bit 7 (lsb index 24) is the target abort flag. Every other bit reads 0, so with all three flags set the word is 0x0700_0000.
- R2: When `sts_wr_en` is high, a 1 in `sts_wr_data` at a flag's position clears that flag on the next edge. A 0 at that position leaves the flag as it was.
- R3: When `max_retries` is between 0x01 and 0xFF, the retry error flag sets on the edge that samples the `max_retries`-th `tgt_retry` pulse of one transaction. It is visible in the following cycle.
- R4: When `max_retries` is 0x00, the retry error flag never sets, whatever the number of retries.
- R5: The per-transaction retry count returns to zero in four cases: when a new transaction starts (`addr_start` with `addr_is_retry` low), on `xfer_done`, on `tgt_abort`, and on an initiator abort. An address phase with `addr_is_retry` high keeps the count.
- R6: After an address phase in cycle A, the cycles A+1 to A+4 form the claim window. If `tgt_devsel` is low in all four, the initiator abort flag is 1 from cycle A+5. A `tgt_devsel` high in any of those cycles prevents the flag.
- R7: A `tgt_abort` pulse in cycle C sets the target abort flag, visible from cycle C+1.
- R8: When a hardware set and a write-1 clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: `irq` is a register holding the OR of the flags ANDed with `irq_en`. The mask bits are [2] retry error, [1] initiator abort and [0] target abort. A flag that sets in cycle C+1 raises `irq` in cycle C+2, and masked flags never drive it.
- R10: While `rst_n` is low, all flags, the retry count, the claim window and `irq` are cleared, so `sts_rd_data` and `irq` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_start | input | 1 | Address phase of an initiator transaction (one-cycle pulse) |
| addr_is_retry | input | 1 | Qualifies `addr_start` as a re-issue of the retried transaction |
| tgt_devsel | input | 1 | A target has claimed the current cycle (level) |
| tgt_retry | input | 1 | Target retry disconnect (pulse) |
| tgt_abort | input | 1 | Target abort signalled (pulse) |
| xfer_done | input | 1 | Transaction completed normally (pulse) |
| max_retries | input | 8 | Retry limit per transaction, 0 means unlimited |
| irq_en | input | 3 | Interrupt enable mask: [2] retry error, [1] initiator abort, [0] target abort |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | 32 | Write-1-to-clear data for the status word |
| sts_rd_data | output | 32 | Status word |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions of this block can fall in the same cycle: a flag's hardware set event and a software write-1 clear of that same flag.

The bench provokes the collision directly by driving a target abort pulse in the same cycle as a write of 1 to the target-abort position. It then judges the result by requiring the flag to read 1 in the next cycle.

The collision is also reached at random. Random status writes overlap randomly timed aborts, retries and unclaimed cycles, and after every cycle the status word and `irq` are compared with a model built from the requirements.

// File: rtl/iem_pkg.sv
package iem_pkg;
  localparam int unsigned STS_W  = 32;
  localparam int unsigned FLAG_N = 3;
  // msb-0 bit k of the status word sits at lsb index STS_W-1-k
  localparam int unsigned POS_RE = STS_W - 1 - 5;
  localparam int unsigned POS_IA = STS_W - 1 - 6;
  localparam int unsigned POS_TA = STS_W - 1 - 7;

  // packed order matches the lsb-index order of the status word
  typedef struct packed {
    logic re;
    logic ia;
    logic ta;
  } flag_vec_t;
endpackage

// File: rtl/iem_retry_tracker.sv
module iem_retry_tracker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_txn,
  input  logic             txn_end,
  input  logic             retry_disc,
  input  logic [CNT_W-1:0] max_retries,
  output logic             retry_err
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             limit_on;
  logic             reset_cnt;

  assign limit_on  = |max_retries;
  assign cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign reset_cnt = new_txn | txn_end;
  // ending or restarting a transaction takes precedence over a retry in the same cycle
  assign retry_err = retry_disc & ~reset_cnt & limit_on & (cnt_inc == max_retries);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reset_cnt || retry_err) begin
      cnt_q <= '0;
    end else if (retry_disc) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/iem_claim_watch.sv
module iem_claim_watch #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_start,
  input  logic devsel,
  output logic unclaimed
);
  localparam int unsigned AGE_W = $clog2(WINDOW + 1);

  logic             armed_q;
  logic [AGE_W-1:0] age_q;

  assign unclaimed = armed_q & ~devsel & (age_q == AGE_W'(WINDOW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (addr_start) begin
      armed_q <= 1'b1;
      age_q   <= AGE_W'(1);
    end else if (armed_q) begin
      if (devsel || unclaimed) begin
        armed_q <= 1'b0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iem_flag_bank.sv
module iem_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
      end else if (set_evt[i]) begin
        flags_q[i] <= 1'b1;
      end else if (clr_req[i]) begin
        flags_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= |(flags_q & irq_en);
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/init_err_monitor.sv
module init_err_monitor
  import iem_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WINDOW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_start,
  input  logic             addr_is_retry,
  input  logic             tgt_devsel,
  input  logic             tgt_retry,
  input  logic             tgt_abort,
  input  logic             xfer_done,
  input  logic [CNT_W-1:0] max_retries,
  input  logic [FLAG_N-1:0] irq_en,
  input  logic             sts_wr_en,
  input  logic [STS_W-1:0] sts_wr_data,
  output logic [STS_W-1:0] sts_rd_data,
  output logic             irq
);
  flag_vec_t   evt;
  flag_vec_t   clr;
  flag_vec_t   flags;
  logic [FLAG_N-1:0] set_evt;
  logic        new_txn;
  logic        txn_end;

  assign new_txn = addr_start & ~addr_is_retry;
  assign txn_end = xfer_done | tgt_abort | evt.ia;
  assign evt.ta  = tgt_abort;

  iem_claim_watch #(.WINDOW(WINDOW)) u_claim (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_start(addr_start),
    .devsel    (tgt_devsel),
    .unclaimed (evt.ia)
  );

  iem_retry_tracker #(.CNT_W(CNT_W)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_txn    (new_txn),
    .txn_end    (txn_end),
    .retry_disc (tgt_retry),
    .max_retries(max_retries),
    .retry_err  (evt.re)
  );

  assign clr.re = sts_wr_en & sts_wr_data[POS_RE];
  assign clr.ia = sts_wr_en & sts_wr_data[POS_IA];
  assign clr.ta = sts_wr_en & sts_wr_data[POS_TA];
  assign set_evt = evt;

  iem_flag_bank #(.N(FLAG_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(evt),
    .clr_req(clr),
    .irq_en (irq_en),
    .flags  (flags),
    .irq    (irq)
  );

  always_comb begin
    sts_rd_data         = '0;
    sts_rd_data[POS_RE] = flags.re;
    sts_rd_data[POS_IA] = flags.ia;
    sts_rd_data[POS_TA] = flags.ta;
  end
endmodule

// File: rtl/iem_checker.sv
module iem_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] sts,
  input logic        irq,
  input logic [2:0]  irq_en,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [7:0]  max_retries,
  input logic [2:0]  set_evt,
  input logic        addr_start
);
  localparam logic [31:0] FLAG_MASK = 32'h0700_0000;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~FLAG_MASK) == 32'h0);

  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((sts[26:24] & $past(wr_data[26:24] & ~set_evt)) == 3'b000));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && set_evt == 3'b000) |=> $stable(sts));

  p_unlimited_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (max_retries == 8'h00) |-> !set_evt[2]);

  p_window_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_start |=> !set_evt[1]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != 3'b000) |=> ((sts[26:24] & $past(set_evt)) == $past(set_evt)));

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(sts[26:24] & irq_en)));
endmodule

bind init_err_monitor iem_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sts        (sts_rd_data),
  .irq        (irq),
  .irq_en     (irq_en),
  .wr_en      (sts_wr_en),
  .wr_data    (sts_wr_data),
  .max_retries(max_retries),
  .set_evt    (set_evt),
  .addr_start (addr_start)
);

// File: tb/tb_init_err_monitor.sv
module tb_init_err_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, addr_start, addr_is_retry, tgt_devsel, tgt_retry, tgt_abort, xfer_done;
  logic [7:0]  max_retries;
  logic [2:0]  irq_en;
  logic        sts_wr_en;
  logic [31:0] sts_wr_data, sts_rd_data;
  logic        irq;

  init_err_monitor dut (
    .clk(clk), .rst_n(rst_n), .addr_start(addr_start), .addr_is_retry(addr_is_retry),
    .tgt_devsel(tgt_devsel), .tgt_retry(tgt_retry), .tgt_abort(tgt_abort),
    .xfer_done(xfer_done), .max_retries(max_retries), .irq_en(irq_en),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // requirement-level cycle model
  logic [2:0]  m_fl, m_set;
  logic        m_irq, m_win, m_end;
  int unsigned m_age, m_rc, m_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fl = 0; m_irq = 0; m_win = 0; m_age = 0; m_rc = 0;
    end else begin
      m_set = 3'b000;
      m_irq = |(m_fl & irq_en);
      if (m_win) begin
        if (tgt_devsel) m_win = 0;
        else if (m_age == 4) begin m_set[1] = 1; m_win = 0; end
        else m_age++;
      end
      if (addr_start) begin m_win = 1; m_age = 1; end
      if (tgt_abort) m_set[0] = 1;
      m_end = xfer_done | tgt_abort | m_set[1] | (addr_start & !addr_is_retry);
      if (m_end) m_rc = 0;
      else if (tgt_retry) begin
        m_n = (m_rc == 255) ? 255 : m_rc + 1;
        if (max_retries != 0 && m_n == max_retries) begin m_set[2] = 1; m_rc = 0; end
        else m_rc = m_n;
      end
      m_fl = m_set | (m_fl & ~(sts_wr_en ? sts_wr_data[26:24] : 3'b000));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic quiet();
    addr_start = 0; addr_is_retry = 0; tgt_devsel = 0; tgt_retry = 0;
    tgt_abort = 0; xfer_done = 0; sts_wr_en = 0; sts_wr_data = 0;
  endtask

  task automatic claim(input logic is_retry);
    addr_start = 1; addr_is_retry = is_retry; step(); addr_start = 0; addr_is_retry = 0;
    tgt_devsel = 1; step(); tgt_devsel = 0;
  endtask

  task automatic retry_once();
    tgt_retry = 1; step(); tgt_retry = 0;
  endtask

  task automatic clear_all();
    sts_wr_en = 1; sts_wr_data = 32'h0700_0000; step(); sts_wr_en = 0; sts_wr_data = 0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] lim [5];
    lim[0] = 8'd0; lim[1] = 8'd1; lim[2] = 8'd2; lim[3] = 8'd3; lim[4] = 8'd255;
    void'($urandom(32'd20240611));
    quiet(); max_retries = 8'd3; irq_en = 3'b000; rst_n = 0;
    step(3);
    rst_n = 1;
    step();
    chk("R10 reset status", sts_rd_data, 32'h0);
    chk("R10 reset irq", {31'h0, irq}, 32'h0);

    // R7 target abort, masked irq
    tgt_abort = 1; step(); tgt_abort = 0;
    chk("R7 target abort flag", sts_rd_data, 32'h0100_0000);
    step();
    chk("R9 masked flag keeps irq low", {31'h0, irq}, 32'h0);
    // R2 write of zeros keeps flag
    sts_wr_en = 1; sts_wr_data = 32'h0; step(); sts_wr_en = 0;
    chk("R2 write zero keeps flag", sts_rd_data, 32'h0100_0000);
    sts_wr_en = 1; sts_wr_data = 32'h0100_0000; step(); sts_wr_en = 0; sts_wr_data = 0;
    chk("R2 write one clears flag", sts_rd_data, 32'h0);

    // R9 irq one cycle after flag
    irq_en = 3'b111;
    tgt_abort = 1; step(); tgt_abort = 0;
    chk("R9 flag set, irq not yet", {sts_rd_data[31:1], irq}, 32'h0100_0000);
    step();
    chk("R9 irq follows flag", {31'h0, irq}, 32'h1);
    // R8 set beats clear
    tgt_abort = 1; sts_wr_en = 1; sts_wr_data = 32'h0100_0000; step();
    tgt_abort = 0; sts_wr_en = 0; sts_wr_data = 0;
    chk("R8 set wins over clear", sts_rd_data, 32'h0100_0000);
    clear_all();
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R6 unclaimed cycle
    addr_start = 1; step(); addr_start = 0;
    chk("R6 window cycle 1", sts_rd_data, 32'h0);
    for (int i = 2; i <= 4; i++) begin
      step();
      chk("R6 inside window", sts_rd_data, 32'h0);
    end
    step();
    chk("R6 initiator abort after window", sts_rd_data, 32'h0200_0000);
    clear_all();
    // R6 claim on the last window cycle
    addr_start = 1; step(); addr_start = 0;
    step(3);
    tgt_devsel = 1; step(); tgt_devsel = 0;
    step(3);
    chk("R6 claim on 4th cycle prevents abort", sts_rd_data, 32'h0);

    // R3 limit of 3
    max_retries = 8'd3;
    claim(0); retry_once(); claim(1); retry_once(); claim(1);
    chk("R3 below limit", sts_rd_data, 32'h0);
    retry_once();
    chk("R3 retry error at limit", sts_rd_data, 32'h0400_0000);
    clear_all();

    // R5 count resets
    max_retries = 8'd2;
    claim(0); retry_once(); claim(0); retry_once();
    chk("R5 new transaction resets count", sts_rd_data, 32'h0);
    claim(1); retry_once();
    chk("R5 retry re-issue keeps count", sts_rd_data, 32'h0400_0000);
    clear_all();
    claim(0); retry_once();
    xfer_done = 1; step(); xfer_done = 0;
    claim(1); retry_once();
    chk("R5 completion resets count", sts_rd_data, 32'h0);
    clear_all();

    // R4 unlimited
    max_retries = 8'd0;
    claim(0);
    repeat (300) begin retry_once(); claim(1); end
    chk("R4 unlimited never flags", sts_rd_data, 32'h0);

    // R1 all flags and reserved bits
    max_retries = 8'd1;
    claim(0); retry_once();
    tgt_abort = 1; step(); tgt_abort = 0;
    addr_start = 1; step(); addr_start = 0; step(4);
    chk("R1 all flags layout", sts_rd_data, 32'h0700_0000);
    sts_wr_en = 1; sts_wr_data = 32'hFFFF_FFFF; step(); sts_wr_en = 0; sts_wr_data = 0;
    chk("R1 R2 full clear", sts_rd_data, 32'h0);
    step(6);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) begin
        max_retries = lim[$urandom % 5];
        irq_en = 3'($urandom);
      end
      addr_start    = ($urandom % 8) == 0;
      addr_is_retry = $urandom % 2;
      tgt_devsel    = ($urandom % 4) == 0;
      tgt_retry     = ($urandom % 5) == 0;
      tgt_abort     = ($urandom % 40) == 0;
      xfer_done     = ($urandom % 10) == 0;
      sts_wr_en     = ($urandom % 12) == 0;
      sts_wr_data   = $urandom;
      step();
      chk("R2 R3 R6 R8 random status", sts_rd_data, {5'b0, m_fl, 24'h0});
      chk("R9 random irq", {31'h0, irq}, {31'h0, m_irq});
    end
    quiet();
    step(2);
    finish_run();
  end
endmodule